// File: doc/BRIEF.md
# Channel Priority Arbiter

This block decides which of six DMA channels owns a single shared bus master port. Every channel carries a request line and a programmable three-bit priority value in the range 0 (lowest) to 5 (highest). While the port is idle, the requesting channel with the largest priority value wins. When several requesting channels share that value, the one with the smallest index wins.

A grant is never taken away in the middle of a transfer. The granted channel presents the length of its current transfer as beats minus one, so 0 means a single access. The bus side pulses a beat-done strobe for each beat it completes. The arbiter releases the port only after the last beat of the transfer. It then spends one idle cycle and re-arbitrates among the requests present in that cycle. Any higher-priority request that arrives during a transfer waits for that transfer to finish.

The grant is a registered one-hot vector, accompanied by the registered index of the owning channel and a valid flag.

Top module: `chan_arbiter`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are `gnt`=0, `gnt_idx`=0 and `gnt_valid`=0. This holds even if a grant was active before.
- R2: When the port is idle and at least one request is high at a clock edge, the port is granted at that edge. The winner is the requesting channel whose 3-bit field `prio[3*i+2:3*i]` holds the largest value. Priority 0 is the lowest and 5 is the highest.
- R3: Among requesting channels with equal priority, the lowest channel index is granted.
- R4: `gnt` is one-hot when `gnt_valid` is 1 and all zeros otherwise. Bit `gnt[gnt_idx]` is the set bit.
- R5: Once granted, `gnt` and `gnt_idx` stay unchanged until the last beat of the transfer completes. This holds whatever happens to the requests or to other priorities, including higher-priority arrivals and cycles without a beat.
- R6: With `burst_len`=0 (a single access), one `beat_done` pulse ends the transfer.
- R7: A transfer of `burst_len`+1 beats ends at the edge that takes its final `beat_done`, and the outputs then read idle for exactly one cycle. At the following edge, arbitration runs on the requests present at that time. This still holds when a higher-priority request is already waiting.
- R8: With no requests, the port stays idle and `gnt` stays all zeros.
- R9: A channel that withdraws its request before the port becomes free is not granted in the next arbitration.
- R10: `beat_done` pulses that arrive while the port is idle are ignored and do not count toward the next transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | NCH (6) | Per-channel request lines |
| prio | input | NCH*PW (18) | Per-channel priority values, PW bits per channel, channel 0 in the low bits |
| burst_len | input | LW (4) | Beats minus one of the granted channel's current transfer, held stable during it |
| beat_done | input | 1 | One-cycle pulse from the bus side per completed beat |
| gnt | output | NCH (6) | Registered one-hot grant |
| gnt_idx | output | IW (3) | Registered index of the granted channel |
| gnt_valid | output | 1 | Registered flag that the port is owned |

## Verification
Two events can fall in the same cycle: the final beat of a low-priority burst, and a waiting higher-priority request. This is provoked by raising the priority-5 request in the middle of a four-beat burst owned by a priority-0 channel. Gaps are inserted between the beats so that the release coincides with the pending request. The outputs are judged after that final beat: they must read idle, and only one cycle later must they show the priority-5 channel, never a switch partway through the burst. A second overlap is also checked: beat pulses seen while the port is idle must not shorten the next transfer.

// File: rtl/chan_arb_pkg.sv
package chan_arb_pkg;
  typedef enum logic {
    ARB_IDLE = 1'b0,
    ARB_BUSY = 1'b1
  } arb_state_e;
endpackage

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
  parameter int NCH = 6,
  parameter int PW  = 3,
  parameter int IW  = 3
) (
  input  logic [NCH-1:0]    req,
  input  logic [NCH*PW-1:0] prio,
  output logic              any,
  output logic [IW-1:0]     idx
);
  logic [PW-1:0] best;

  // Scan from the top index down; ">=" lets a lower index take a tie.
  always_comb begin
    any  = 1'b0;
    idx  = '0;
    best = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i] && (!any || prio[i*PW +: PW] >= best)) begin
        any  = 1'b1;
        idx  = IW'(i);
        best = prio[i*PW +: PW];
      end
    end
  end

  // R2
  always_comb begin
    if (any) begin
      pick_req_chk: assert (req[idx]);
    end
  end
endmodule

// File: rtl/arb_beat_count.sv
module arb_beat_count #(
  parameter int LW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          busy,
  input  logic          beat,
  input  logic [LW-1:0] len,
  output logic          last
);
  logic [LW-1:0] cnt_q;

  assign last = busy && beat && (cnt_q == len);

  always_ff @(posedge clk) begin
    if (rst || !busy || last) begin
      cnt_q <= '0;
    end else if (beat) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R10
  idle_beat_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy) |=> (cnt_q == '0));

  // R5
  beat_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && beat && !last) |=> (cnt_q == $past(cnt_q) + 1'b1));
endmodule

// File: rtl/chan_arbiter.sv
module chan_arbiter
  import chan_arb_pkg::*;
#(
  parameter int NCH = 6,
  parameter int PW  = 3,
  parameter int LW  = 4,
  localparam int IW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NCH-1:0]    req,
  input  logic [NCH*PW-1:0] prio,
  input  logic [LW-1:0]     burst_len,
  input  logic              beat_done,
  output logic [NCH-1:0]    gnt,
  output logic [IW-1:0]     gnt_idx,
  output logic              gnt_valid
);
  arb_state_e     st_q;
  logic           pick_any;
  logic [IW-1:0]  pick_idx;
  logic [NCH-1:0] pick_oh;
  logic           xfer_last;

  arb_prio_pick #(.NCH(NCH), .PW(PW), .IW(IW)) u_pick (
    .req  (req),
    .prio (prio),
    .any  (pick_any),
    .idx  (pick_idx)
  );

  arb_beat_count #(.LW(LW)) u_beats (
    .clk  (clk),
    .rst  (rst),
    .busy (st_q == ARB_BUSY),
    .beat (beat_done),
    .len  (burst_len),
    .last (xfer_last)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_oh
    assign pick_oh[g] = (pick_idx == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ARB_IDLE;
      gnt     <= '0;
      gnt_idx <= '0;
    end else if (st_q == ARB_BUSY) begin
      if (xfer_last) begin
        st_q    <= ARB_IDLE;
        gnt     <= '0;
        gnt_idx <= '0;
      end
    end else if (pick_any) begin
      st_q    <= ARB_BUSY;
      gnt     <= pick_oh;
      gnt_idx <= pick_idx;
    end
  end

  assign gnt_valid = (st_q == ARB_BUSY);

  // R4
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt) && (gnt_valid == (gnt != '0)) &&
    (!gnt_valid || ((gnt >> gnt_idx) & NCH'(1)) != '0));

  // R2
  idle_grant_chk: assert property (@(posedge clk) disable iff (rst)
    (!gnt_valid && (req != '0)) |=> gnt_valid);

  // R8
  no_req_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!gnt_valid && (req == '0)) |=> (!gnt_valid && gnt == '0));

  // R5
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && !xfer_last) |=> (gnt_valid && $stable(gnt) && $stable(gnt_idx)));

  // R7
  release_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (gnt_valid && xfer_last) |=> !gnt_valid);
endmodule

// File: tb/chan_arbiter_bench.sv
module chan_arbiter_bench;
  typedef struct packed {
    logic [5:0]  req;
    logic [17:0] pr;
    logic [2:0]  idx;
  } vec_t;

  // prio fields: {ch5, ch4, ch3, ch2, ch1, ch0}, 3 bits each
  localparam vec_t VECS [6] = '{
    '{6'b000001, {3'd0, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0}, 3'd0},
    '{6'b111111, {3'd1, 3'd1, 3'd5, 3'd1, 3'd1, 3'd1}, 3'd3},
    '{6'b101010, {3'd4, 3'd0, 3'd4, 3'd0, 3'd2, 3'd5}, 3'd3},
    '{6'b110000, {3'd0, 3'd0, 3'd5, 3'd5, 3'd5, 3'd5}, 3'd4},
    '{6'b100001, {3'd5, 3'd5, 3'd5, 3'd5, 3'd5, 3'd0}, 3'd5},
    '{6'b011110, {3'd0, 3'd3, 3'd3, 3'd3, 3'd3, 3'd4}, 3'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  req = '0;
  logic [17:0] prio = '0;
  logic [3:0]  blen = '0;
  logic        beat = 1'b0;
  logic [5:0]  gnt;
  logic [2:0]  gidx;
  logic        gvld;
  int          checks = 0;
  int          fails = 0;
  bit          fin = 1'b0;

  always #10 clk = ~clk;

  chan_arbiter u_chan_arbiter (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .prio      (prio),
    .burst_len (blen),
    .beat_done (beat),
    .gnt       (gnt),
    .gnt_idx   (gidx),
    .gnt_valid (gvld)
  );

  function automatic logic [9:0] ex(int ch);
    return {1'b1, 3'(ch), 6'(1 << ch)};
  endfunction

  task automatic chk(string tag, logic [9:0] expv);
    checks++;
    if ({gvld, gidx, gnt} !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, {gvld, gidx, gnt}, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic beat1();
    beat = 1'b1;
    step();
    beat = 1'b0;
  endtask

  initial begin
    repeat (3) step();
    rst = 1'b0;
    chk("R1 reset state", '0);

    // vector table: R2 priority, R3 ties, R4 encoding, R6 single release
    for (int v = 0; v < 6; v++) begin
      req  = VECS[v].req;
      prio = VECS[v].pr;
      blen = '0;
      step();
      chk("R2/R3/R4 vector grant", ex(int'(VECS[v].idx)));
      req = '0;
      beat1();
      chk("R6 single access release", '0);
    end

    // R8 idle with no requests
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R8 no request idle", '0);
    end

    // R10 idle beats are ignored
    for (int k = 0; k < 3; k++) begin
      beat1();
      chk("R10 idle beat", '0);
    end
    prio = {3'd0, 3'd0, 3'd0, 3'd2, 3'd0, 3'd0};
    req  = 6'b000100;
    blen = 4'd1;
    step();
    chk("R10 grant after idle beats", ex(2));
    req = '0;
    beat1();
    chk("R10 first beat not last", ex(2));
    beat1();
    chk("R10 release after two beats", '0);

    // R5 / R7 burst held against higher-priority arrival
    prio = {3'd5, 3'd0, 3'd0, 3'd0, 3'd0, 3'd0};
    req  = 6'b000001;
    blen = 4'd3;
    step();
    chk("R5 burst grant", ex(0));
    req = 6'b100001;
    step();
    chk("R5 hold on arrival", ex(0));
    beat1();
    chk("R5 hold beat1", ex(0));
    step();
    chk("R5 hold gap", ex(0));
    beat1();
    chk("R5 hold beat2", ex(0));
    beat1();
    chk("R5 hold beat3", ex(0));
    beat1();
    chk("R7 idle after last beat", '0);
    step();
    chk("R7 rearbitration", ex(5));
    req  = '0;
    blen = '0;
    beat1();
    chk("R7 release", '0);

    // R9 withdrawn request not granted
    prio = {3'd0, 3'd5, 3'd0, 3'd0, 3'd1, 3'd0};
    req  = 6'b000010;
    step();
    chk("R9 first grant", ex(1));
    req = 6'b010110;
    step();
    chk("R9 hold", ex(1));
    req = 6'b000100;
    beat1();
    chk("R9 release", '0);
    step();
    chk("R9 withdrawn skipped", ex(2));
    req = '0;
    beat1();

    // R1 reset while granted
    req = 6'b000001;
    step();
    chk("R1 pre-reset grant", ex(0));
    rst = 1'b1;
    step();
    chk("R1 reset clears grant", '0);
    rst = 1'b0;
    req = '0;
    step();
    chk("R1 idle after reset", '0);

    fin = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!fin) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule